// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block gathers six reset requests and turns them into one internal reset. The sources are power-on, an active-low external reset pad, a watchdog timeout, a low-voltage detector, an illegal-opcode trap and an illegal-address trap. Internal sources pull the shared pad low through an open-drain enable. The pad is held low for a fixed pulse so that external devices see the reset. Internal reset then stays active for a further hold window. Power-on and low-voltage resets first run a long stretch before that pulse. While any internal sequence runs, the block drives a clear for the free-running system counter. An external pad reset holds internal reset but leaves that counter untouched.

A six-bit status register records which sources fired. Reading the register clears it. The block also presents the reset vector address, which depends on a monitor-mode input. The watchdog request and the pad input are asynchronous, so each passes through its own synchroniser. The power-on request acts as the block's own asynchronous reset.

Top module: `reset_sequencer`

## Requirements
- R1: While `porReq` is high and after it falls, `statusOut` reads exactly 6'b000001, with `intReset` and `pinDriveEn` high. Status bit encoding: bit 0 power-on, bit 1 pad, bit 2 watchdog, bit 3 low-voltage, bit 4 illegal opcode, bit 5 illegal address.
- R2: After `porReq` falls, `pinDriveEn` stays high for STRETCH_CYCLES+PULSE_CYCLES-1 clock cycles. `intReset` then stays high for HOLD_CYCLES more cycles.
- R3: A one-cycle `lvdReq` starts a sequence at the next clock edge. `pinDriveEn` is high for STRETCH_CYCLES+PULSE_CYCLES cycles and `intReset` for STRETCH_CYCLES+PULSE_CYCLES+HOLD_CYCLES cycles.
- R4: A one-cycle `badOpReq`, `badAddrReq` or `wdogReq` drives `pinDriveEn` high for PULSE_CYCLES cycles and `intReset` high for PULSE_CYCLES+HOLD_CYCLES cycles. The two trap requests take effect at the next edge. The watchdog request takes effect SYNC_STAGES+1 edges after it is sampled high.
- R5: Each request sets its own status bit, and the bit stays set until a read.
- R6: `statusRead` sampled high at an edge clears every status bit at that edge. A source setting a bit in the same cycle wins.
- R7: A pad low run shorter than MIN_PIN_LOW cycles is ignored: `intReset` stays low and no status bit is set.
- R8: A pad low run of L >= MIN_PIN_LOW cycles sets status bit 1 and holds `intReset` high for L-MIN_PIN_LOW+1 cycles. `pinDriveEn` stays low throughout.
- R9: `cntClear` is high during internal-source sequences and never during an external pad reset.
- R10: A `lvdReq` during a running sequence restarts it from the stretch. A trap or watchdog request during a sequence only sets its status bit.
- R11: `vectorAddr` is 16'hFFFE when `monitorMode` is low and 16'hFEFE when it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| porReq | input | 1 | Power-on request, active high, asynchronous reset of the block |
| pinIn | input | 1 | Level read back from the active-low reset pad |
| wdogReq | input | 1 | Watchdog timeout request, asynchronous |
| lvdReq | input | 1 | Low-voltage detect request, synchronous |
| badOpReq | input | 1 | Illegal-opcode request, synchronous |
| badAddrReq | input | 1 | Illegal-address request, synchronous |
| monitorMode | input | 1 | Selects the monitor reset vector |
| statusRead | input | 1 | Read strobe that clears the status register |
| statusOut | output | 6 | Reset status register |
| pinDriveEn | output | 1 | Pull the reset pad low when high |
| intReset | output | 1 | Internal reset, active high |
| cntClear | output | 1 | Clear for the system counter |
| vectorAddr | output | 16 | Reset vector address |

## Verification
Each result is due at a fixed point after its stimulus. Status bits are due one edge after a trap or low-voltage request, and SYNC_STAGES+1 edges after a watchdog request. A read clears the register one edge after `statusRead`. A pad reset qualifies MIN_PIN_LOW+3 edges after the pad falls. A monitor samples a quarter period after each rising edge. It measures the length of every run of `pinDriveEn` and `intReset` and compares each length with the item the driver queued before the stimulus. The run lengths therefore do not depend on request latency. Status and vector values are read once the sequence has ended.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  localparam int NUM_SRC  = 6;
  localparam int SRC_POR  = 0;
  localparam int SRC_PIN  = 1;
  localparam int SRC_WDOG = 2;
  localparam int SRC_LVD  = 3;
  localparam int SRC_OP   = 4;
  localparam int SRC_ADDR = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STRETCH,
    ST_PULSE,
    ST_HOLD,
    ST_EXT
  } seqState_t;

  typedef struct packed {
    logic cntRestart;
    logic cntRun;
    logic armFilter;
    logic setPin;
  } seqStrobe_t;

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or posedge arst) begin
        if (arst) chain <= RST_VAL;
        else      chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or posedge arst) begin
        if (arst) chain <= {STAGES{RST_VAL}};
        else      chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/rstseq_dp.sv
module rstseq_dp
  import rstseq_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter int          MIN_PIN_LOW = 4,
  parameter int          CNT_W       = 13,
  parameter logic [15:0] VEC_NORMAL  = 16'hFFFE,
  parameter logic [15:0] VEC_MONITOR = 16'hFEFE
) (
  input  logic               clk,
  input  logic               porReq,
  input  logic               pinIn,
  input  logic               wdogReq,
  input  logic               lvdReq,
  input  logic               badOpReq,
  input  logic               badAddrReq,
  input  logic               monitorMode,
  input  logic               statusRead,
  input  seqStrobe_t         strobe,
  output logic [CNT_W-1:0]   cnt,
  output logic               pinLong,
  output logic               wdogSync,
  output logic [NUM_SRC-1:0] statusOut,
  output logic [15:0]        vectorAddr
);

  localparam int FILT_W = $clog2(MIN_PIN_LOW + 1);

  logic              pinSync;
  logic [FILT_W-1:0] filterCnt;
  logic [NUM_SRC-1:0] setVec;

  rstseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) pinSyncInst (
    .clk(clk), .arst(porReq), .d(pinIn), .q(pinSync)
  );

  rstseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) wdogSyncInst (
    .clk(clk), .arst(porReq), .d(wdogReq), .q(wdogSync)
  );

  // Glitch filter on the synchronised pad level.
  always_ff @(posedge clk or posedge porReq) begin
    if (porReq)                             filterCnt <= '0;
    else if (!strobe.armFilter || pinSync)  filterCnt <= '0;
    else if (filterCnt != FILT_W'(MIN_PIN_LOW)) filterCnt <= filterCnt + 1'b1;
  end

  assign pinLong = (filterCnt == FILT_W'(MIN_PIN_LOW));

  // Shared sequence counter.
  always_ff @(posedge clk or posedge porReq) begin
    if (porReq)                 cnt <= '0;
    else if (strobe.cntRestart) cnt <= '0;
    else if (strobe.cntRun)     cnt <= cnt + 1'b1;
  end

  always_comb begin
    setVec           = '0;
    setVec[SRC_PIN]  = strobe.setPin;
    setVec[SRC_WDOG] = wdogSync;
    setVec[SRC_LVD]  = lvdReq;
    setVec[SRC_OP]   = badOpReq;
    setVec[SRC_ADDR] = badAddrReq;
  end

  always_ff @(posedge clk or posedge porReq) begin
    if (porReq) begin
      statusOut          <= '0;
      statusOut[SRC_POR] <= 1'b1;
    end else begin
      statusOut <= (statusRead ? '0 : statusOut) | setVec;
    end
  end

  assign vectorAddr = monitorMode ? VEC_MONITOR : VEC_NORMAL;

endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
  import rstseq_pkg::*;
#(
  parameter int STRETCH_CYCLES = 4096,
  parameter int PULSE_CYCLES   = 32,
  parameter int HOLD_CYCLES    = 32,
  parameter int CNT_W          = 13
) (
  input  logic             clk,
  input  logic             porReq,
  input  logic [CNT_W-1:0] cnt,
  input  logic             pinLong,
  input  logic             wdogSync,
  input  logic             lvdReq,
  input  logic             badOpReq,
  input  logic             badAddrReq,
  output seqStrobe_t       strobe,
  output logic             pinDriveEn,
  output logic             intReset,
  output logic             cntClear
);

  seqState_t state, nxtState;
  logic      restart;
  logic      internalReq;
  logic      lastStretch, lastPulse, lastHold;

  assign internalReq = wdogSync | badOpReq | badAddrReq;
  assign lastStretch = (cnt == CNT_W'(STRETCH_CYCLES - 1));
  assign lastPulse   = (cnt == CNT_W'(PULSE_CYCLES - 1));
  assign lastHold    = (cnt == CNT_W'(HOLD_CYCLES - 1));

  always_comb begin
    nxtState = state;
    restart  = 1'b0;
    if (lvdReq) begin
      nxtState = ST_STRETCH;
      restart  = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (internalReq) begin
            nxtState = ST_PULSE;
            restart  = 1'b1;
          end else if (pinLong) begin
            nxtState = ST_EXT;
          end
        end
        ST_EXT: begin
          if (internalReq) begin
            nxtState = ST_PULSE;
            restart  = 1'b1;
          end else if (!pinLong) begin
            nxtState = ST_IDLE;
          end
        end
        ST_STRETCH: begin
          if (lastStretch) begin
            nxtState = ST_PULSE;
            restart  = 1'b1;
          end
        end
        ST_PULSE: begin
          if (lastPulse) begin
            nxtState = ST_HOLD;
            restart  = 1'b1;
          end
        end
        ST_HOLD: begin
          if (lastHold) begin
            if (internalReq) begin
              nxtState = ST_PULSE;
              restart  = 1'b1;
            end else begin
              nxtState = ST_IDLE;
            end
          end
        end
        default: nxtState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or posedge porReq) begin
    if (porReq) state <= ST_STRETCH;
    else        state <= nxtState;
  end

  always_comb begin
    strobe.cntRestart = restart;
    strobe.cntRun     = (state == ST_STRETCH) || (state == ST_PULSE) || (state == ST_HOLD);
    strobe.armFilter  = (state == ST_IDLE) || (state == ST_EXT);
    strobe.setPin     = (state == ST_IDLE) && pinLong;
  end

  assign pinDriveEn = (state == ST_STRETCH) || (state == ST_PULSE);
  assign intReset   = (state != ST_IDLE);
  assign cntClear   = intReset && (state != ST_EXT);

endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import rstseq_pkg::*;
#(
  parameter int          SYNC_STAGES    = 2,
  parameter int          MIN_PIN_LOW    = 4,
  parameter int          STRETCH_CYCLES = 4096,
  parameter int          PULSE_CYCLES   = 32,
  parameter int          HOLD_CYCLES    = 32,
  parameter logic [15:0] VEC_NORMAL     = 16'hFFFE,
  parameter logic [15:0] VEC_MONITOR    = 16'hFEFE
) (
  input  logic               clk,
  input  logic               porReq,
  input  logic               pinIn,
  input  logic               wdogReq,
  input  logic               lvdReq,
  input  logic               badOpReq,
  input  logic               badAddrReq,
  input  logic               monitorMode,
  input  logic               statusRead,
  output logic [NUM_SRC-1:0] statusOut,
  output logic               pinDriveEn,
  output logic               intReset,
  output logic               cntClear,
  output logic [15:0]        vectorAddr
);

  localparam int SPAN_A   = (STRETCH_CYCLES > PULSE_CYCLES) ? STRETCH_CYCLES : PULSE_CYCLES;
  localparam int MAX_SPAN = (SPAN_A > HOLD_CYCLES) ? SPAN_A : HOLD_CYCLES;
  localparam int CNT_W    = $clog2(MAX_SPAN + 1);

  seqStrobe_t       strobe;
  logic [CNT_W-1:0] cnt;
  logic             pinLong;
  logic             wdogSync;

  rstseq_ctrl #(
    .STRETCH_CYCLES(STRETCH_CYCLES),
    .PULSE_CYCLES(PULSE_CYCLES),
    .HOLD_CYCLES(HOLD_CYCLES),
    .CNT_W(CNT_W)
  ) ctrlInst (
    .clk(clk), .porReq(porReq), .cnt(cnt), .pinLong(pinLong),
    .wdogSync(wdogSync), .lvdReq(lvdReq), .badOpReq(badOpReq),
    .badAddrReq(badAddrReq), .strobe(strobe), .pinDriveEn(pinDriveEn),
    .intReset(intReset), .cntClear(cntClear)
  );

  rstseq_dp #(
    .SYNC_STAGES(SYNC_STAGES),
    .MIN_PIN_LOW(MIN_PIN_LOW),
    .CNT_W(CNT_W),
    .VEC_NORMAL(VEC_NORMAL),
    .VEC_MONITOR(VEC_MONITOR)
  ) dpInst (
    .clk(clk), .porReq(porReq), .pinIn(pinIn), .wdogReq(wdogReq),
    .lvdReq(lvdReq), .badOpReq(badOpReq), .badAddrReq(badAddrReq),
    .monitorMode(monitorMode), .statusRead(statusRead), .strobe(strobe),
    .cnt(cnt), .pinLong(pinLong), .wdogSync(wdogSync),
    .statusOut(statusOut), .vectorAddr(vectorAddr)
  );

endmodule

// File: rtl/rstseq_checker.sv
module rstseq_checker #(
  parameter int HOLD_CYCLES = 32
) (
  input logic       clk,
  input logic       porReq,
  input logic       badOpReq,
  input logic       lvdReq,
  input logic       statusRead,
  input logic [5:0] statusOut,
  input logic       pinDriveEn,
  input logic       intReset,
  input logic       cntClear
);

  localparam int HC_W = $clog2(HOLD_CYCLES + 2);

  logic [HC_W-1:0] holdCnt;
  logic            afterDrive;

  always_ff @(posedge clk or posedge porReq) begin
    if (porReq) begin
      holdCnt    <= '0;
      afterDrive <= 1'b0;
    end else if (pinDriveEn) begin
      holdCnt    <= '0;
      afterDrive <= 1'b1;
    end else if (intReset && afterDrive) begin
      holdCnt <= holdCnt + 1'b1;
    end else if (!intReset) begin
      holdCnt    <= '0;
      afterDrive <= 1'b0;
    end
  end

  assert_drive_in_reset_R2: assert property (@(posedge clk) disable iff (porReq)
    pinDriveEn |-> intReset);

  assert_hold_window_R2: assert property (@(posedge clk) disable iff (porReq)
    (afterDrive && !intReset) |-> (holdCnt == HC_W'(HOLD_CYCLES)));

  assert_trap_starts_R4: assert property (@(posedge clk) disable iff (porReq)
    badOpReq |=> (intReset && statusOut[4]));

  assert_lvd_stretch_R3: assert property (@(posedge clk) disable iff (porReq)
    lvdReq |=> (pinDriveEn && cntClear));

  assert_read_clears_R6: assert property (@(posedge clk) disable iff (porReq)
    statusRead |=> !statusOut[0]);

  assert_clear_in_reset_R9: assert property (@(posedge clk) disable iff (porReq)
    cntClear |-> intReset);

endmodule

bind reset_sequencer rstseq_checker #(.HOLD_CYCLES(HOLD_CYCLES)) chkInst (
  .clk(clk), .porReq(porReq), .badOpReq(badOpReq), .lvdReq(lvdReq),
  .statusRead(statusRead), .statusOut(statusOut), .pinDriveEn(pinDriveEn),
  .intReset(intReset), .cntClear(cntClear)
);

// File: tb/reset_sequencer_test.sv
module reset_sequencer_test;

  localparam int PERIOD  = 10;
  localparam int SYNC    = 2;
  localparam int MINLOW  = 4;
  localparam int STRETCH = 4096;
  localparam int PULSE   = 32;
  localparam int HOLD    = 32;

  logic       clk = 1'b0;
  logic       porReq = 1'b1;
  logic       pinPull = 1'b0;
  logic       wdogReq = 1'b0, lvdReq = 1'b0, badOpReq = 1'b0, badAddrReq = 1'b0;
  logic       monitorMode = 1'b0, statusRead = 1'b0;
  logic [5:0] statusOut;
  logic       pinDriveEn, intReset, cntClear;
  logic [15:0] vectorAddr;
  logic       pinIn;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int    pinQ[$];
  string pinTag[$];
  int    rstQ[$];
  string rstTag[$];

  int pinRun = 0, rstRun = 0;
  int clrSeen = 0, rstSeen = 0, driveSeen = 0;

  assign pinIn = (pinPull || pinDriveEn) ? 1'b0 : 1'b1;

  always #(PERIOD/2) clk = ~clk;

  reset_sequencer #(
    .SYNC_STAGES(SYNC), .MIN_PIN_LOW(MINLOW), .STRETCH_CYCLES(STRETCH),
    .PULSE_CYCLES(PULSE), .HOLD_CYCLES(HOLD)
  ) uut (
    .clk(clk), .porReq(porReq), .pinIn(pinIn), .wdogReq(wdogReq),
    .lvdReq(lvdReq), .badOpReq(badOpReq), .badAddrReq(badAddrReq),
    .monitorMode(monitorMode), .statusRead(statusRead), .statusOut(statusOut),
    .pinDriveEn(pinDriveEn), .intReset(intReset), .cntClear(cntClear),
    .vectorAddr(vectorAddr)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expectPin(input int len, input string tag);
    pinQ.push_back(len);
    pinTag.push_back(tag);
  endtask

  task automatic expectRst(input int len, input string tag);
    rstQ.push_back(len);
    rstTag.push_back(tag);
  endtask

  // Monitor: measures run lengths a quarter period after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #(PERIOD/4);
      if (!porReq) begin
        if (cntClear)   clrSeen++;
        if (intReset)   rstSeen++;
        if (pinDriveEn) driveSeen++;
        if (pinDriveEn) pinRun++;
        else if (pinRun > 0) begin
          if (pinQ.size() == 0) check(0, "unexpected pin run", pinRun, 0);
          else check(pinRun == pinQ[0], pinTag[0], pinRun, pinQ[0]);
          if (pinQ.size() > 0) begin
            void'(pinQ.pop_front());
            void'(pinTag.pop_front());
          end
          pinRun = 0;
        end
        if (intReset) rstRun++;
        else if (rstRun > 0) begin
          if (rstQ.size() == 0) check(0, "unexpected reset run", rstRun, 0);
          else check(rstRun == rstQ[0], rstTag[0], rstRun, rstQ[0]);
          if (rstQ.size() > 0) begin
            void'(rstQ.pop_front());
            void'(rstTag.pop_front());
          end
          rstRun = 0;
        end
      end
    end
  end

  task automatic waitIdle();
    repeat (5) @(negedge clk);
    while (intReset) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic readStatus();
    @(negedge clk); statusRead = 1'b1;
    @(negedge clk); statusRead = 1'b0;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      check(0, "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1/R2: power-on
    expectPin(STRETCH + PULSE - 1, "R2 pin run after power-on");
    expectRst(STRETCH + PULSE - 1 + HOLD, "R2 reset run after power-on");
    repeat (5) @(negedge clk);
    check(statusOut == 6'b000001, "R1 status in power-on", statusOut, 1);
    check(intReset && pinDriveEn, "R1 outputs in power-on", {intReset, pinDriveEn}, 3);
    porReq = 1'b0;
    clrSeen = 0;
    waitIdle();
    check(statusOut == 6'b000001, "R1 status after power-on", statusOut, 1);
    check(clrSeen > 0, "R9 clear during power-on", clrSeen, 1);
    check(vectorAddr == 16'hFFFE, "R11 normal vector", vectorAddr, 16'hFFFE);
    readStatus();
    check(statusOut == 6'b0, "R6 read clears", statusOut, 0);

    // R4: illegal opcode
    expectPin(PULSE, "R4 pin run opcode");
    expectRst(PULSE + HOLD, "R4 reset run opcode");
    pulse(badOpReq);
    waitIdle();
    check(statusOut == 6'b010000, "R5 opcode bit", statusOut, 6'b010000);
    @(negedge clk); monitorMode = 1'b1; #1;
    check(vectorAddr == 16'hFEFE, "R11 monitor vector", vectorAddr, 16'hFEFE);
    monitorMode = 1'b0;
    readStatus();

    // R4: watchdog, asynchronous edge
    expectPin(PULSE, "R4 pin run watchdog");
    expectRst(PULSE + HOLD, "R4 reset run watchdog");
    @(negedge clk); #3 wdogReq = 1'b1;
    @(negedge clk); #3 wdogReq = 1'b0;
    waitIdle();
    check(statusOut == 6'b000100, "R5 watchdog bit", statusOut, 6'b000100);
    readStatus();

    // R4: illegal address
    expectPin(PULSE, "R4 pin run address");
    expectRst(PULSE + HOLD, "R4 reset run address");
    pulse(badAddrReq);
    waitIdle();
    check(statusOut == 6'b100000, "R5 address bit", statusOut, 6'b100000);
    readStatus();

    // R3: low voltage
    expectPin(STRETCH + PULSE, "R3 pin run low-voltage");
    expectRst(STRETCH + PULSE + HOLD, "R3 reset run low-voltage");
    clrSeen = 0;
    pulse(lvdReq);
    waitIdle();
    check(statusOut == 6'b001000, "R5 low-voltage bit", statusOut, 6'b001000);
    check(clrSeen == STRETCH + PULSE + HOLD, "R9 clear span low-voltage", clrSeen, STRETCH + PULSE + HOLD);
    readStatus();

    // R7: short pad glitch
    rstSeen = 0;
    @(negedge clk); pinPull = 1'b1;
    repeat (MINLOW - 1) @(negedge clk);
    pinPull = 1'b0;
    repeat (12) @(negedge clk);
    check(statusOut == 6'b0, "R7 glitch sets no bit", statusOut, 0);
    check(rstSeen == 0, "R7 glitch no reset", rstSeen, 0);

    // R8/R9: external pad reset
    expectRst(6, "R8 reset run pad");
    clrSeen = 0; driveSeen = 0;
    @(negedge clk); pinPull = 1'b1;
    repeat (MINLOW + 5) @(negedge clk);
    pinPull = 1'b0;
    repeat (12) @(negedge clk);
    check(statusOut == 6'b000010, "R8 pad bit", statusOut, 6'b000010);
    check(driveSeen == 0, "R8 pad not driven", driveSeen, 0);
    check(clrSeen == 0, "R9 no clear on pad reset", clrSeen, 0);
    readStatus();

    // R10: restart by low voltage during hold, trap during stretch
    expectPin(PULSE, "R10 first pin run");
    expectPin(STRETCH + PULSE, "R10 restarted pin run");
    expectRst(PULSE + 5 + STRETCH + PULSE + HOLD, "R10 merged reset run");
    pulse(badOpReq);
    @(negedge clk);
    while (pinDriveEn) @(negedge clk);
    repeat (4) @(negedge clk);
    lvdReq = 1'b1;
    @(negedge clk); lvdReq = 1'b0;
    repeat (100) @(negedge clk);
    pulse(badAddrReq);
    waitIdle();
    check(statusOut == 6'b111000, "R10 status after restart", statusOut, 6'b111000);
    readStatus();

    repeat (4) @(negedge clk);
    check(pinQ.size() == 0 && rstQ.size() == 0, "scoreboard drained",
          pinQ.size() + rstQ.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule